// File: doc/BRIEF.md
# DMA Request Activation Sequencer

This block decides when a DMA channel may begin a transfer. It watches an external active-low request pin, resamples it into the engine clock domain, and runs a three-state sequencer. In edge mode the sequencer turns level sensing into falling-edge detection. It sees a low level, then waits for the engine to report that a transfer can proceed. It then fires one activation and refuses further requests until the pin has returned high. The first activation after the channel is enabled therefore needs only a low level, not a true edge. A low level present before enable counts as a request.

The same sequencer serves two other request sources chosen by a mode input. In level mode the channel activates each time the pin is low and the engine is ready. In interrupt mode an internal request line replaces the pin. The output is a single-cycle activation pulse to the engine. Address and count registers, bus cycles and transfer-end signalling belong to other blocks.

Sequencer states: `ST_ARM` waits for a request. `ST_HOLD` holds an accepted request until the engine is ready. `ST_BLOCK` ignores the pin until it is seen high. Transitions:
- ARM→HOLD on a request.
- HOLD→BLOCK on engine ready, in edge mode, with a pulse.
- HOLD→ARM on engine ready, in level or interrupt mode, with a pulse.
- HOLD→ARM when the request is withdrawn, in level or interrupt mode, without a pulse.
- BLOCK→ARM when the pin is high.
- Any state→ARM while the channel is disabled.

Top module: `dreq_act_ctrl`

## Requirements
- R1: The pin passes through SYNC_STAGES flip-flops on `clk`. In edge mode with `xfer_ok` held high, `act_pulse` is first sampled high SYNC_STAGES+2 clock edges after the pin falls.
- R2: In ST_ARM, a synchronised low pin (edge or level mode) or a high `irq_req` (interrupt mode) moves the sequencer to ST_HOLD.
- R3: In edge mode, ST_HOLD with `xfer_ok` high fires one activation and moves to ST_BLOCK. An accepted request stays pending even if the pin returns high before `xfer_ok`.
- R4: In edge mode, ST_BLOCK returns to ST_ARM only once the pin is seen high. A pin held low gives exactly one activation, however many `xfer_ok` strobes follow.
- R5: Enabling the channel starts the sequencer in ST_ARM, so a pin already low before enable is accepted as a request.
- R6: While `chan_en` is low the sequencer is forced to ST_ARM and `act_pulse` stays low, whatever `xfer_ok` does.
- R7: `act_pulse` is registered and never high for two consecutive cycles.
- R8: In level mode, each `xfer_ok` strobe while the pin stays low yields one activation. If the pin rises while in ST_HOLD, the request is dropped without activation.
- R9: In interrupt mode the pin is ignored and each `xfer_ok` strobe while `irq_req` is high yields one activation. An `irq_req` pending before enable is accepted.
- R10: Mode encoding: 0 edge, 1 level, 2 interrupt. The reserved value 3 behaves as edge mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Engine clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n_pin | input | 1 | Raw external request, active low, asynchronous |
| irq_req | input | 1 | Internal interrupt request, synchronous to clk |
| chan_en | input | 1 | Channel enable |
| sense_mode | input | 2 | 0 edge, 1 level, 2 interrupt, 3 as edge |
| xfer_ok | input | 1 | Engine reports a transfer can start now |
| act_pulse | output | 1 | One-cycle activation to the engine |

## Verification
The bench builds the block with SYNC_STAGES=2, so the pin-to-pulse latency is a fixed four edges and can be measured exactly. In every mode it sweeps one to four ready strobes against held requests and repeated pin toggles. This shows the single activation per low phase in edge mode against one per strobe in level and interrupt modes. It also covers pending requests at enable, disable while a request is held, withdrawal before the engine is ready, and the reserved mode value.

// File: rtl/dreq_pkg.sv
package dreq_pkg;

    typedef enum logic [1:0] {
        SENSE_EDGE  = 2'd0,
        SENSE_LEVEL = 2'd1,
        SENSE_IRQ   = 2'd2,
        SENSE_RSVD  = 2'd3
    } sense_mode_t;

    typedef enum logic [1:0] {
        ST_ARM   = 2'd0,
        ST_HOLD  = 2'd1,
        ST_BLOCK = 2'd2
    } act_state_t;

endpackage

// File: rtl/dreq_sync.sv
module dreq_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= RST_VAL;
                else        chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= {STAGES{RST_VAL}};
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/dreq_src_sel.sv
module dreq_src_sel
    import dreq_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       pin_low,
    input  logic       irq_req,
    output logic       req_active,
    output logic       edge_mode
);
    sense_mode_t m;
    assign m = sense_mode_t'(mode);

    always_comb begin
        unique case (m)
            SENSE_EDGE:  begin req_active = pin_low; edge_mode = 1'b1; end
            SENSE_LEVEL: begin req_active = pin_low; edge_mode = 1'b0; end
            SENSE_IRQ:   begin req_active = irq_req; edge_mode = 1'b0; end
            default:     begin req_active = pin_low; edge_mode = 1'b1; end
        endcase
    end
endmodule

// File: rtl/dreq_seq.sv
module dreq_seq
    import dreq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chan_en,
    input  logic       edge_mode,
    input  logic       req_active,
    input  logic       xfer_ok,
    output logic       act_pulse,
    output act_state_t state_o
);
    act_state_t cur_q, nxt;
    logic       fire;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= ST_ARM;
        else        cur_q <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = cur_q;
        if (!chan_en) begin
            nxt = ST_ARM;
        end else begin
            unique case (cur_q)
                ST_ARM: begin
                    if (req_active) nxt = ST_HOLD;
                end
                ST_HOLD: begin
                    if (edge_mode) begin
                        if (xfer_ok) nxt = ST_BLOCK;
                    end else if (!req_active) begin
                        nxt = ST_ARM;
                    end else if (xfer_ok) begin
                        nxt = ST_ARM;
                    end
                end
                ST_BLOCK: begin
                    if (!edge_mode || !req_active) nxt = ST_ARM;
                end
                default: nxt = ST_ARM;
            endcase
        end
    end

    assign fire = chan_en && (cur_q == ST_HOLD) && xfer_ok
                  && (edge_mode || req_active);

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_pulse <= 1'b0;
        else        act_pulse <= fire;
    end

    assign state_o = cur_q;
endmodule

// File: rtl/dreq_act_ctrl.sv
module dreq_act_ctrl
    import dreq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_n_pin,
    input  logic       irq_req,
    input  logic       chan_en,
    input  logic [1:0] sense_mode,
    input  logic       xfer_ok,
    output logic       act_pulse
);
    logic       pin_sync;
    logic       pin_low;
    logic       req_active;
    logic       edge_mode;
    act_state_t cur_state;

    dreq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (req_n_pin),
        .q     (pin_sync)
    );

    assign pin_low = ~pin_sync;

    dreq_src_sel u_sel (
        .mode       (sense_mode),
        .pin_low    (pin_low),
        .irq_req    (irq_req),
        .req_active (req_active),
        .edge_mode  (edge_mode)
    );

    dreq_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .chan_en    (chan_en),
        .edge_mode  (edge_mode),
        .req_active (req_active),
        .xfer_ok    (xfer_ok),
        .act_pulse  (act_pulse),
        .state_o    (cur_state)
    );
endmodule

// File: rtl/dreq_act_ctrl_chk.sv
module dreq_act_ctrl_chk
    import dreq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chan_en,
    input  logic [1:0] sense_mode,
    input  logic       xfer_ok,
    input  logic       irq_req,
    input  logic       pin_low,
    input  logic       act_pulse,
    input  act_state_t cur_state
);
    p_single_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        act_pulse |=> !act_pulse);

    p_quiet_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> (!act_pulse && cur_state == ST_ARM));

    p_needs_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        act_pulse |-> $past(xfer_ok));

    p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (act_pulse && $past(sense_mode) == 2'd2) |-> $past(irq_req));

    p_level_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (act_pulse && $past(sense_mode) == 2'd1) |-> $past(pin_low));

    p_block_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_BLOCK && chan_en && pin_low && sense_mode[1] == sense_mode[0])
        |=> cur_state == ST_BLOCK);
endmodule

bind dreq_act_ctrl dreq_act_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .chan_en    (chan_en),
    .sense_mode (sense_mode),
    .xfer_ok    (xfer_ok),
    .irq_req    (irq_req),
    .pin_low    (pin_low),
    .act_pulse  (act_pulse),
    .cur_state  (cur_state)
);

// File: tb/dreq_act_ctrl_bench.sv
module dreq_act_ctrl_bench;
    localparam int SYNC = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_n_pin = 1'b1;
    logic       irq_req = 1'b0;
    logic       chan_en = 1'b0;
    logic [1:0] sense_mode = 2'd0;
    logic       xfer_ok = 1'b0;
    logic       act_pulse;

    int total = 0;
    int bad = 0;
    int pulses = 0;
    int high_cycles = 0;
    logic prev_act = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dreq_act_ctrl #(.SYNC_STAGES(SYNC)) u_dreq_act_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_n_pin  (req_n_pin),
        .irq_req    (irq_req),
        .chan_en    (chan_en),
        .sense_mode (sense_mode),
        .xfer_ok    (xfer_ok),
        .act_pulse  (act_pulse)
    );

    always @(negedge clk) begin
        if (act_pulse) begin
            high_cycles <= high_cycles + 1;
            if (!prev_act) pulses <= pulses + 1;
        end
        prev_act <= act_pulse;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic strobe();
        @(negedge clk) xfer_ok = 1'b1;
        @(negedge clk) xfer_ok = 1'b0;
        idle(3);
    endtask

    task automatic quiesce(input logic [1:0] m);
        @(negedge clk);
        chan_en = 1'b0; xfer_ok = 1'b0; req_n_pin = 1'b1; irq_req = 1'b0;
        sense_mode = m;
        idle(6);
    endtask

    initial begin
        int base;
        int lat;
        idle(3);
        chk(act_pulse == 1'b0, "R6 reset", int'(act_pulse), 0);
        @(negedge clk) rst_n = 1'b1;
        idle(2);

        // R1 latency
        quiesce(2'd0);
        chan_en = 1'b1; xfer_ok = 1'b1; idle(6);
        base = pulses;
        req_n_pin = 1'b0;
        lat = 0;
        for (int c = 1; c <= 20; c++) begin
            @(negedge clk);
            if (act_pulse && lat == 0) lat = c;
        end
        chk(lat == SYNC + 2, "R1 latency", lat, SYNC + 2);
        chk(pulses - base == 1, "R4 held low with ready high", pulses - base, 1);
        xfer_ok = 1'b0;

        // Sweep of strobe counts over modes (R4, R8, R10)
        for (int mi = 0; mi < 4; mi++) begin
            if (mi == 2) continue;
            for (int n = 1; n <= 4; n++) begin
                int exp;
                quiesce(mi[1:0]);
                chan_en = 1'b1; req_n_pin = 1'b0; idle(6);
                base = pulses;
                for (int k = 0; k < n; k++) strobe();
                exp = (mi == 1) ? n : 1;
                chk(pulses - base == exp,
                    (mi == 1) ? "R8 level strobes" : ((mi == 3) ? "R10 reserved as edge" : "R4 edge strobes"),
                    pulses - base, exp);
            end
        end

        // R2/R3/R4: repeated pin toggles in edge mode
        for (int m = 1; m <= 3; m++) begin
            quiesce(2'd0);
            chan_en = 1'b1; req_n_pin = 1'b0; idle(6);
            base = pulses;
            strobe();
            for (int t = 0; t < m; t++) begin
                req_n_pin = 1'b1; idle(5);
                req_n_pin = 1'b0; idle(5);
                strobe();
            end
            chk(pulses - base == m + 1, "R2 edge toggles", pulses - base, m + 1);
        end

        // R3 latched request in edge mode
        quiesce(2'd0);
        chan_en = 1'b1; req_n_pin = 1'b0; idle(6);
        req_n_pin = 1'b1; idle(6);
        base = pulses;
        strobe();
        chk(pulses - base == 1, "R3 latched edge request", pulses - base, 1);

        // R8 withdrawn request in level mode
        quiesce(2'd1);
        chan_en = 1'b1; req_n_pin = 1'b0; idle(6);
        req_n_pin = 1'b1; idle(6);
        base = pulses;
        strobe();
        chk(pulses - base == 0, "R8 level withdraw", pulses - base, 0);

        // R5 pending low before enable
        quiesce(2'd0);
        req_n_pin = 1'b0; idle(10);
        chan_en = 1'b1; idle(6);
        base = pulses;
        strobe();
        chk(pulses - base == 1, "R5 pending low at enable", pulses - base, 1);

        // R6 disable while holding, then re-enable
        quiesce(2'd0);
        chan_en = 1'b1; req_n_pin = 1'b0; idle(6);
        chan_en = 1'b0; idle(2);
        base = pulses;
        strobe(); strobe();
        chk(pulses - base == 0, "R6 disabled strobes", pulses - base, 0);
        chan_en = 1'b1; idle(6);
        base = pulses;
        strobe();
        chk(pulses - base == 1, "R6 re-enable restarts", pulses - base, 1);

        // R9 interrupt mode
        for (int n = 1; n <= 4; n++) begin
            quiesce(2'd2);
            chan_en = 1'b1; req_n_pin = 1'b0; idle(6);
            base = pulses;
            strobe();
            chk(pulses - base == 0, "R9 pin ignored", pulses - base, 0);
            irq_req = 1'b1; idle(3);
            base = pulses;
            for (int k = 0; k < n; k++) strobe();
            chk(pulses - base == n, "R9 irq strobes", pulses - base, n);
        end
        quiesce(2'd2);
        irq_req = 1'b1; idle(8);
        chan_en = 1'b1; idle(4);
        base = pulses;
        strobe();
        chk(pulses - base == 1, "R9 pending irq at enable", pulses - base, 1);

        // R7 ready held high in level mode
        quiesce(2'd1);
        chan_en = 1'b1; req_n_pin = 1'b0; idle(6);
        base = pulses;
        xfer_ok = 1'b1; idle(20); xfer_ok = 1'b0; idle(4);
        chk(pulses - base >= 9, "R8 level continuous", pulses - base, 10);
        chk(high_cycles == pulses, "R7 one-cycle pulses", high_cycles, pulses);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule